// File: doc/BRIEF.md
# Sleep-Aware Clock Output Controller

This block produces the clock that a companion microcontroller receives on a single output pin. In normal operation the pin carries either a division of a fast timing reference or a copy of a separate 32.768 kHz low-power clock. A 3-bit setting in a writable 8-bit control register chooses which. The reference input runs at 60 MHz, twice the 30 MHz crystal rate, so that the 30 MHz setting and the 4 MHz setting are both whole divisions.

When sleep is requested, the block does one of two things. It can switch the pin over to the low-power clock. Otherwise it keeps the current clock running for a programmed tail of 0, 128, 256 or 512 full periods and then holds the pin low. A pending interrupt delays any sleep action until the interrupt flag clears. Every change of source, ratio or gating happens at a falling edge of the output, so the pin never carries a shortened high pulse. A 2-bit status output tells the microcontroller which of the four conditions the block is in.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset `clk_out` is low and `status` reads running. The control register resets to 0x06 (1 MHz), and the first full output period lasts 60 reference cycles.
- R2: Control register layout: bits 5:4 hold the tail code, bit 3 enables the low-power fallback, and bits 2:0 hold the frequency select. Writes to bits 7:6 have no effect.
- R3: Selects 0 to 6 give output periods of 2, 4, 6, 15, 20, 30 and 60 reference cycles (30, 15, 10, 4, 3, 2 and 1 MHz). The high phase lasts floor(period/2) cycles.
- R4: Select 7 makes the output follow the synchronised low-power clock, one period per period of that clock.
- R5: A new select takes effect at the next falling edge of the output. Across any change, no high pulse is shorter than the shorter high phase of the old and new settings.
- R6: With the fallback disabled and tail code 00, a sleep request turns the output off at its next falling edge. The output then stays low and `status` reads off.
- R7: Tail codes 01, 10 and 11 give exactly 128, 256 and 512 full output periods while `status` reads tail. The output then stops low and `status` reads off.
- R8: With the fallback enabled, a sleep request switches the output to the low-power clock, whatever the select, and `status` reads low-power. When the request is removed, the selected frequency returns and `status` reads running.
- R9: While `irq_pend` is high, a sleep request has no effect and the output keeps its setting. The sleep action starts only after the flag clears. An interrupt raised during a tail returns the block to running.
- R10: `status` encoding: 00 off, 01 running, 10 tail countdown, 11 low-power sleep clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 60 MHz timing reference; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| lf_clk | input | 1 | 32.768 kHz low-power clock, asynchronous |
| sleep_req | input | 1 | Request to enter sleep |
| irq_pend | input | 1 | Interrupt pending flag; holds off sleep |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| clk_out | output | 1 | Clock to the microcontroller |
| status | output | 2 | Condition code (R10) |

## Verification
The bench measures every divider ratio at the pin. A counter applied off by one, or a wrong duty split, shows up as a wrong period or high-phase length. It switches settings during operation and tracks the shortest high pulse, so a design that reloads the divider in mid-phase leaves a runt pulse behind. It counts the output's rising edges during each tail length, which catches a countdown that stops one period early or late. It also raises the interrupt flag both before a sleep request and during a tail, which catches a design that gates the clock despite a pending interrupt.

// File: rtl/sleep_clk_pkg.sv
package sleep_clk_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_RUN  = 2'b01,
        ST_TAIL = 2'b10,
        ST_LF   = 2'b11
    } sc_state_e;

    localparam int CNT_W = 6;

    typedef struct packed {
        logic [1:0] tail;
        logic       lfen;
        logic [2:0] sel;
    } sc_cfg_t;

    localparam sc_cfg_t CFG_RESET = '{tail: 2'd0, lfen: 1'b0, sel: 3'd6};

    // reference cycles per output period for each select code
    function automatic logic [CNT_W-1:0] div_ratio(input logic [2:0] sel);
        case (sel)
            3'd0:    div_ratio = 6'd2;
            3'd1:    div_ratio = 6'd4;
            3'd2:    div_ratio = 6'd6;
            3'd3:    div_ratio = 6'd15;
            3'd4:    div_ratio = 6'd20;
            3'd5:    div_ratio = 6'd30;
            default: div_ratio = 6'd60;
        endcase
    endfunction

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sc_cfg.sv
module sc_cfg
    import sleep_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output sc_cfg_t    cfg
);
    sc_cfg_t cfg_d, cfg_q;
    logic    unused_hi;

    assign unused_hi = ^wdata[7:6];

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = sc_cfg_t'(wdata[5:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import sleep_clk_pkg::*;
#(
    parameter int TAIL_UNIT   = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       lf_clk,
    input  logic       sleep_req,
    input  logic       irq_pend,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic       clk_out,
    output logic [1:0] status
);
    localparam int TCNT_W = $clog2(4 * TAIL_UNIT + 1);

    typedef struct packed {
        sc_state_e          st;
        logic [2:0]         sel;
        logic [1:0]         tsel;
        logic [CNT_W-1:0]   cnt;
        logic               arm;
        logic               out;
        logic [TCNT_W-1:0]  tcnt;
    } regs_t;

    sc_cfg_t           cfg_q;
    logic              lf_s;
    regs_t             r_d, r_q;
    logic              use_lf, src_out, fall, eff_sleep;
    logic [CNT_W-1:0]  ratio, hi, new_hi;
    logic [TCNT_W-1:0] target;

    sc_cfg u_cfg (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    sc_sync #(.STAGES(SYNC_STAGES)) u_lf_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (lf_clk),
        .q     (lf_s)
    );

    always_comb begin
        case (r_q.tsel)
            2'd2:    target = TCNT_W'(2 * TAIL_UNIT);
            2'd3:    target = TCNT_W'(4 * TAIL_UNIT);
            default: target = TCNT_W'(TAIL_UNIT);
        endcase
    end

    always_comb begin
        r_d       = r_q;
        use_lf    = (r_q.st == ST_LF) || (r_q.sel == 3'd7);
        ratio     = div_ratio(r_q.sel);
        hi        = ratio >> 1;
        new_hi    = div_ratio(cfg_q.sel) >> 1;
        eff_sleep = sleep_req && !irq_pend;

        // source step: low-power follower or integer divider
        if (use_lf) begin
            r_d.arm = r_q.arm || !lf_s;
            src_out = lf_s && r_q.arm;
            fall    = r_q.out && !src_out;
        end else begin
            r_d.cnt = (r_q.cnt == ratio - 6'd1) ? '0 : r_q.cnt + 6'd1;
            src_out = r_d.cnt < hi;
            fall    = (r_q.cnt == hi - 6'd1);
        end
        r_d.out = src_out;

        case (r_q.st)
            ST_RUN, ST_TAIL: begin
                // falling edge: safe point to reload the setting
                if (fall) begin
                    r_d.sel = cfg_q.sel;
                    r_d.cnt = new_hi;
                    r_d.arm = 1'b0;
                    r_d.out = 1'b0;
                end
                if (r_q.st == ST_RUN) begin
                    if (fall && eff_sleep) begin
                        r_d.tcnt = '0;
                        r_d.tsel = cfg_q.tail;
                        if (cfg_q.lfen)               r_d.st = ST_LF;
                        else if (cfg_q.tail == 2'd0)  r_d.st = ST_OFF;
                        else                          r_d.st = ST_TAIL;
                    end
                end else if (!eff_sleep) begin
                    r_d.st = ST_RUN;
                end else if (fall) begin
                    r_d.tcnt = r_q.tcnt + 1'b1;
                    if (r_d.tcnt == target) r_d.st = ST_OFF;
                end
            end
            ST_LF: begin
                if (!eff_sleep && !src_out) begin
                    r_d.st  = ST_RUN;
                    r_d.sel = cfg_q.sel;
                    r_d.cnt = new_hi;
                    r_d.arm = 1'b0;
                    r_d.out = 1'b0;
                end
            end
            default: begin
                r_d.cnt = r_q.cnt;
                r_d.arm = r_q.arm;
                r_d.out = 1'b0;
                if (!eff_sleep) begin
                    r_d.st  = ST_RUN;
                    r_d.sel = cfg_q.sel;
                    r_d.cnt = new_hi;
                    r_d.arm = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RUN;
            r_q.sel  <= CFG_RESET.sel;
            r_q.tsel <= 2'd0;
            r_q.cnt  <= div_ratio(CFG_RESET.sel) >> 1;
            r_q.arm  <= 1'b0;
            r_q.out  <= 1'b0;
            r_q.tcnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_out = r_q.out;
    assign status  = r_q.st;

    // R6: the pin is low whenever the block reports off
    p_off_low_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (status == 2'b00) |-> !clk_out);

    // R6: the off state is entered only under an unmasked sleep request
    p_off_entry_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(status == 2'b00) |-> $past(sleep_req && !irq_pend));

    // R7: the tail count never reaches its target while still counting
    p_tail_bound_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (r_q.st == ST_TAIL) |-> (r_q.tcnt < target));

    // R8: low-power sleep is entered only with the fallback enabled
    p_lf_entry_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(status == 2'b11) |-> $past(cfg_q.lfen));

    // R9: a pending interrupt keeps the block running
    p_irq_hold_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (irq_pend && status == 2'b01) |=> (status == 2'b01));
endmodule

// File: tb/sleep_clk_ctrl_bench.sv
module sleep_clk_ctrl_bench;

    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lf_clk = 1'b0;
    logic       sleep_req = 1'b0;
    logic       irq_pend = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       clk_out;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 ref_clk = ~ref_clk;
    always #108 lf_clk = ~lf_clk;   // 27 reference cycles per period

    sleep_clk_ctrl u_sleep_clk_ctrl (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .lf_clk    (lf_clk),
        .sleep_req (sleep_req),
        .irq_pend  (irq_pend),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .clk_out   (clk_out),
        .status    (status)
    );

    // monitor: tail rises and shortest high pulse
    logic prev_out = 1'b0;
    int   tail_rises = 0;
    int   hcount = 0;
    int   min_high = 999;
    bit   track = 1'b0;

    always @(negedge ref_clk) begin
        if (clk_out && !prev_out && status == 2'b10) tail_rises++;
        if (clk_out) hcount++;
        else begin
            if (prev_out && track && hcount < min_high) min_high = hcount;
            hcount = 0;
        end
        prev_out = clk_out;
    end

    always @(posedge ref_clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp below 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge ref_clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge ref_clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_level(input logic v);
        for (int i = 0; i < 5000; i++) begin
            @(negedge ref_clk);
            if (clk_out == v) break;
        end
    endtask

    task automatic measure(output int per, output int hi);
        int lo;
        wait_level(1'b0);
        wait_level(1'b1);
        hi = 1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge ref_clk);
            if (clk_out) hi++;
            else break;
        end
        lo = 1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge ref_clk);
            if (!clk_out) lo++;
            else break;
        end
        per = hi + lo;
    endtask

    task automatic wait_status(input logic [1:0] s);
        for (int i = 0; i < 20000; i++) begin
            @(negedge ref_clk);
            if (status == s) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    typedef struct packed {
        logic [2:0] sel;
        logic [7:0] per;
        logic [7:0] hi;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{3'd0, 8'd2,  8'd1},
        '{3'd1, 8'd4,  8'd2},
        '{3'd2, 8'd6,  8'd3},
        '{3'd3, 8'd15, 8'd7},
        '{3'd4, 8'd20, 8'd10},
        '{3'd5, 8'd30, 8'd15},
        '{3'd6, 8'd60, 8'd30},
        '{3'd7, 8'd27, 8'd0}
    };

    initial begin
        int per, hi;

        // R1 / R10 reset state
        idle(5);
        check(clk_out == 1'b0, "R1 reset clk_out", int'(clk_out), 0);
        check(status == 2'b01, "R10 reset status", int'(status), 1);
        rst_n = 1'b1;
        measure(per, hi);
        check(per == 60, "R1 default period", per, 60);
        check(hi == 30, "R1 default high", hi, 30);

        // R2 R3 R4 table walk; bits 7:6 set to show they are ignored
        foreach (VECS[k]) begin
            write_cfg({2'b11, 2'b00, 1'b0, VECS[k].sel});
            measure(per, hi);
            measure(per, hi);
            if (VECS[k].sel == 3'd7) begin
                check(per >= 26 && per <= 28, "R4 low-power period", per, 27);
            end else begin
                check(per == int'(VECS[k].per), "R3 R2 period", per, int'(VECS[k].per));
                check(hi == int'(VECS[k].hi), "R3 high phase", hi, int'(VECS[k].hi));
            end
        end

        // R5 changes only at falling edges, no runt high pulse
        write_cfg(8'h06);
        measure(per, hi);
        measure(per, hi);
        min_high = 999;
        track = 1'b1;
        write_cfg(8'h02);
        measure(per, hi);
        measure(per, hi);
        write_cfg(8'h07);
        measure(per, hi);
        measure(per, hi);
        write_cfg(8'h06);
        measure(per, hi);
        measure(per, hi);
        track = 1'b0;
        check(min_high >= 3, "R5 shortest high pulse", min_high, 3);
        check(per == 60, "R5 period after switching", per, 60);

        // R9 interrupt holds off sleep
        write_cfg(8'h00);
        irq_pend = 1'b1;
        sleep_req = 1'b1;
        idle(200);
        check(status == 2'b01, "R9 status while irq pending", int'(status), 1);
        measure(per, hi);
        check(per == 2, "R9 period while irq pending", per, 2);

        // R6 irq clears, tail 0: off at next fall
        irq_pend = 1'b0;
        idle(20);
        check(status == 2'b00, "R6 status off", int'(status), 0);
        begin
            int highs = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge ref_clk);
                if (clk_out) highs++;
            end
            check(highs == 0, "R6 output held low", highs, 0);
        end
        sleep_req = 1'b0;
        idle(20);
        check(status == 2'b01, "R10 wake status", int'(status), 1);
        measure(per, hi);
        check(per == 2, "R6 period after wake", per, 2);

        // R7 tail lengths
        for (int t = 1; t <= 3; t++) begin
            write_cfg({2'b00, 2'(t), 1'b0, 3'd0});
            idle(4);
            tail_rises = 0;
            sleep_req = 1'b1;
            wait_status(2'b00);
            check(tail_rises == (128 << (t - 1)), "R7 tail periods", tail_rises, 128 << (t - 1));
            sleep_req = 1'b0;
            idle(10);
        end
        write_cfg({2'b00, 2'd1, 1'b0, 3'd3});
        idle(20);
        tail_rises = 0;
        sleep_req = 1'b1;
        wait_status(2'b00);
        check(tail_rises == 128, "R7 tail at 4 MHz", tail_rises, 128);
        check(clk_out == 1'b0, "R7 output low after tail", int'(clk_out), 0);
        sleep_req = 1'b0;
        idle(20);

        // R9 interrupt during tail returns to running
        write_cfg({2'b00, 2'd3, 1'b0, 3'd0});
        idle(4);
        sleep_req = 1'b1;
        idle(100);
        check(status == 2'b10, "R10 tail status", int'(status), 2);
        irq_pend = 1'b1;
        idle(3);
        check(status == 2'b01, "R9 irq during tail", int'(status), 1);
        sleep_req = 1'b0;
        irq_pend = 1'b0;
        idle(10);

        // R8 low-power fallback in sleep
        write_cfg({2'b00, 2'd2, 1'b1, 3'd0});
        idle(4);
        sleep_req = 1'b1;
        idle(40);
        check(status == 2'b11, "R8 low-power status", int'(status), 3);
        measure(per, hi);
        measure(per, hi);
        check(per >= 26 && per <= 28, "R8 low-power period", per, 27);
        sleep_req = 1'b0;
        idle(60);
        check(status == 2'b01, "R8 status after wake", int'(status), 1);
        measure(per, hi);
        measure(per, hi);
        check(per == 2, "R8 restored period", per, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule